// File: doc/BRIEF.md
# Register-Programmed Clause-22 Management Master

This block drives a clause-22 management interface (MDC clock, MDIO data) to a PHY. Software programs it through three 32-bit registers on a plain write/read bus: a command word, a data word and a feature word. When the command word is written with a valid request, the block sends one complete read or write frame to the selected PHY register. On a read it stores the returned 16-bit value in the data word. When the frame ends it clears the bit that started the command.

Two command encodings share the controller, and feature bit 31 picks between them at the moment a command is accepted. The new encoding carries a fire bit, a start-code check, a 2-bit operation code and the write data, all inside the command word. The legacy encoding uses separate read and write strobes, takes write data from the low half of the data word and returns read data in its high half. While a frame is running the block reports busy, and any command-word write is discarded.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, all three registers read as zero, and `busy`, `mdc` and `mdio_oe` are low. Register addresses are: 0 command, 1 data, 2 feature. Address 3 reads zero.
- R2: Feature bit 31 set selects the new encoding and clear selects the legacy encoding. The value sampled when the command word is written governs that command.
- R3: New encoding fields are: write data [31:16], fire bit 15, start flag 12, op [11:10], PHY address [9:5], register [4:0]. Op 1 sends a write frame. The write frame is 32 ones, then 01, op 01, PHY address, register address (both MSB first), turnaround 10, and the 16 data bits MSB first. MDIO is driven for all 64 bits.
- R4: A read frame uses op 10. MDIO is driven for the first 46 bits and released for the turnaround and the 16 data bits. Data is sampled on each rising MDC edge. In the new encoding the result lands in data[15:0], with data[31:16] cleared.
- R5: In the new encoding, fire bit 15 clears when the frame ends. All other command bits keep their written values.
- R6: In the new encoding, a command with the fire bit set and start flag 12 clear starts no frame. The command word keeps the written value.
- R7: In the new encoding, fire with the start flag set and op 0 or 3 starts no frame. The word is stored with bit 15 cleared.
- R8: Legacy fields are: write strobe 27, read strobe 26, register [25:21], PHY address [20:16]. A write strobe sends data[15:0]. When both strobes are set, the write wins.
- R9: A legacy read stores the result as {result, 16'h0000} in the data word. Both strobe bits clear when the frame ends.
- R10: A legacy command word with neither strobe set starts no frame.
- R11: `busy` is high for the whole frame, and command-word writes during that time are ignored. MDC has a period of 2*DIV system clocks.
- R12: When idle, MDC is low and MDIO is released (`mdio_oe` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 command, 1 data, 2 feature) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| busy | output | 1 | A frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or shift register shows up within one frame as a wrong bit pattern on MDIO or a wrong enable window. It also shows as a read value shifted into the wrong place in the data word, visible as soon as `busy` falls. A wrong style latch or decode shows either as a frame that should not exist, which appears as MDC edges within a few cycles of the write, or as a command bit left set when the frame ends. A broken busy interlock shows as a command word altered in mid-frame, or as a second frame that differs from the expected pattern.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_FEAT = 2'd2;

    localparam int NEW_FIRE   = 15;
    localparam int NEW_ST     = 12;
    localparam int LEG_WR     = 27;
    localparam int LEG_RD     = 26;
    localparam int FEAT_NEW   = 31;

    typedef struct packed {
        logic        start;
        logic        is_read;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] d;
        op = c.is_read ? 2'b10 : 2'b01;
        ta = c.is_read ? 2'b11 : 2'b10;
        d  = c.is_read ? 16'hFFFF : c.wdata;
        return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
    import mdio_pkg::*;
(
    input  logic [31:0] ctrl_word,
    input  logic [15:0] data_lo,
    input  logic        new_style,
    output mdio_cmd_t   cmd,
    output logic        drop_fire
);
    logic [1:0] op;
    logic       op_ok;

    assign op    = ctrl_word[11:10];
    assign op_ok = (op == 2'b01) || (op == 2'b10);

    always_comb begin
        cmd       = '0;
        drop_fire = 1'b0;
        if (new_style) begin
            cmd.start   = ctrl_word[NEW_FIRE] && ctrl_word[NEW_ST] && op_ok;
            cmd.is_read = (op == 2'b10);
            cmd.phy     = ctrl_word[9:5];
            cmd.regad   = ctrl_word[4:0];
            cmd.wdata   = ctrl_word[31:16];
            drop_fire   = ctrl_word[NEW_FIRE] && ctrl_word[NEW_ST] && !op_ok;
        end else begin
            cmd.start   = ctrl_word[LEG_WR] || ctrl_word[LEG_RD];
            cmd.is_read = !ctrl_word[LEG_WR] && ctrl_word[LEG_RD];
            cmd.phy     = ctrl_word[20:16];
            cmd.regad   = ctrl_word[25:21];
            cmd.wdata   = data_lo;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        run,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    logic                  tick;
    logic                  phase;
    logic                  rd;
    logic [BW-1:0]         bitidx;
    logic [FRAME_BITS-1:0] shreg;

    mdio_clk_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (run),
        .tick (tick)
    );

    assign done    = run && tick && phase && (bitidx == LAST_BIT);
    assign mdc     = run && phase;
    assign mdio_o  = run ? shreg[FRAME_BITS-1] : 1'b0;
    assign mdio_oe = run && (!rd || (bitidx < BW'(TA_IDX)));

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= 1'b0;
            phase  <= 1'b0;
            rd     <= 1'b0;
            bitidx <= '0;
            shreg  <= '0;
            rdata  <= '0;
        end else if (!run) begin
            if (start) begin
                run    <= 1'b1;
                phase  <= 1'b0;
                rd     <= cmd.is_read;
                bitidx <= '0;
                shreg  <= build_frame(cmd);
            end
        end else if (tick) begin
            if (!phase) begin
                phase <= 1'b1;
                if (rd && (bitidx >= BW'(DATA_IDX))) begin
                    rdata <= {rdata[14:0], mdio_i};
                end
            end else begin
                phase <= 1'b0;
                if (bitidx == LAST_BIT) begin
                    run <= 1'b0;
                end else begin
                    bitidx <= bitidx + 1'b1;
                    shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wen,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [31:0] ctrl_q;
    logic [31:0] data_q;
    logic [31:0] feat_q;
    logic        run_new;
    logic        run_read;
    mdio_cmd_t   cmd;
    logic        drop_fire;
    logic        ctrl_wr;
    logic        start;
    logic        done;
    logic [15:0] rdata;

    mdio_cmd_decode u_dec (
        .ctrl_word (bus_wdata),
        .data_lo   (data_q[15:0]),
        .new_style (feat_q[FEAT_NEW]),
        .cmd       (cmd),
        .drop_fire (drop_fire)
    );

    assign ctrl_wr = bus_wen && (bus_addr == ADDR_CTRL) && !busy;
    assign start   = ctrl_wr && cmd.start;

    mdio_frame_engine #(.DIV(DIV)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd     (cmd),
        .mdio_i  (mdio_i),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .run     (busy),
        .done    (done),
        .rdata   (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            data_q   <= '0;
            feat_q   <= '0;
            run_new  <= 1'b0;
            run_read <= 1'b0;
        end else begin
            if (start) begin
                run_new  <= feat_q[FEAT_NEW];
                run_read <= cmd.is_read;
            end
            if (done) begin
                if (run_new) begin
                    ctrl_q[NEW_FIRE] <= 1'b0;
                    if (run_read) data_q <= {16'h0000, rdata};
                end else begin
                    ctrl_q[LEG_WR] <= 1'b0;
                    ctrl_q[LEG_RD] <= 1'b0;
                    if (run_read) data_q <= {rdata, 16'h0000};
                end
            end
            if (bus_wen) begin
                case (bus_addr)
                    ADDR_CTRL: if (!busy) begin
                        ctrl_q <= drop_fire ? (bus_wdata & ~(32'd1 << NEW_FIRE)) : bus_wdata;
                    end
                    ADDR_DATA: data_q <= bus_wdata;
                    ADDR_FEAT: feat_q <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_DATA: bus_rdata = data_q;
            ADDR_FEAT: bus_rdata = feat_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        bus_wen,
    input logic [1:0]  bus_addr,
    input logic [31:0] ctrl_q,
    input logic        run_new
);
    a_r12_mdc_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    a_r12_oe_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    a_r11_ctrl_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(ctrl_q)));

    a_r11_start_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_wen && (bus_addr == 2'd0)));

    a_r5_r9_cmd_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_new ? !ctrl_q[15] : (ctrl_q[27:26] == 2'b00)));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .ctrl_q   (ctrl_q),
    .run_new  (run_new)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wen;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        busy;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #10 clk = ~clk;

    mdio_master #(.DIV(DIV)) dut (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [63:0] cap_d;
    logic [63:0] cap_oe;
    int          rises;
    int          falls;
    logic [15:0] phy_val;
    longint      cyc = 0;
    longint      last_rise = 0;
    longint      period = 0;

    always @(posedge clk) cyc++;
    always @(posedge mdc) begin
        cap_d  = {cap_d[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        rises++;
        period    = cyc - last_rise;
        last_rise = cyc;
    end
    always @(negedge mdc) falls++;

    assign mdio_i = (falls >= 48 && falls < 64) ? phy_val[63 - falls] : 1'b1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic issue(input logic [31:0] c);
        falls = 0; rises = 0; cap_d = '0; cap_oe = '0;
        wr(2'd0, c);
        wait_idle();
    endtask

    function automatic logic [63:0] exp_frame(input bit r, input logic [4:0] p,
                                               input logic [4:0] g, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g,
                (r ? 2'b11 : 2'b10), (r ? 16'hFFFF : d)};
    endfunction

    function automatic logic [31:0] new_word(input logic [15:0] d, input logic fire,
                                             input logic st, input logic [1:0] op,
                                             input logic [4:0] p, input logic [4:0] g);
        return {d, fire, 2'b00, st, op, p, g};
    endfunction

    function automatic logic [31:0] leg_word(input logic w, input logic r,
                                             input logic [4:0] p, input logic [4:0] g);
        return {4'h0, w, r, g, p, 16'h0000};
    endfunction

    localparam logic [63:0] RD_OE = 64'hFFFF_FFFF_FFFC_0000;
    localparam logic [63:0] RD_MASK = 64'hFFFF_FFFF_FFFC_0000;

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c;
        logic [31:0] dval;
        logic [4:0]  p, g;
        logic [15:0] d;
        bit          isnew, isrd;
        int          r0;

        void'($urandom(32'h5EED_0042));
        rst = 1'b1; bus_wen = 1'b0; bus_addr = 2'd0; bus_wdata = '0; phy_val = '0;
        falls = 0; rises = 0; cap_d = '0; cap_oe = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, v); chk("R1 ctrl", 64'(v), 64'h0);
        rd(2'd1, v); chk("R1 data", 64'(v), 64'h0);
        rd(2'd2, v); chk("R1 feat", 64'(v), 64'h0);
        rd(2'd3, v); chk("R1 addr3", 64'(v), 64'h0);
        chk("R1 pins", {61'h0, busy, mdc, mdio_oe}, 64'h0);

        // R2/R3/R4/R5/R8/R9: random transactions in both encodings
        for (int n = 0; n < 12; n++) begin
            isnew = $urandom() % 2 == 1;
            isrd  = $urandom() % 2 == 1;
            p = 5'($urandom()); g = 5'($urandom()); d = 16'($urandom());
            phy_val = 16'($urandom());
            dval = $urandom();
            wr(2'd2, isnew ? 32'h8000_0000 : 32'h0000_0000);
            wr(2'd1, dval);
            if (isnew) c = new_word(d, 1'b1, 1'b1, isrd ? 2'b10 : 2'b01, p, g);
            else begin
                c = leg_word(!isrd, isrd, p, g);
                d = dval[15:0];
            end
            issue(c);
            if (isrd) begin
                chk(isnew ? "R4 new read frame" : "R9 legacy read frame",
                    cap_d & RD_MASK, exp_frame(1'b1, p, g, d) & RD_MASK);
                chk("R4 read oe window", cap_oe, RD_OE);
                rd(2'd1, v);
                chk(isnew ? "R4 new read data" : "R9 legacy read data", 64'(v),
                    isnew ? 64'({16'h0, phy_val}) : 64'({phy_val, 16'h0}));
            end else begin
                chk(isnew ? "R3 new write frame" : "R8 legacy write frame",
                    cap_d, exp_frame(1'b0, p, g, d));
                chk("R3 write oe", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
                rd(2'd1, v);
                chk("R2 data kept on write", 64'(v), 64'(dval));
            end
            rd(2'd0, v);
            chk(isnew ? "R5 fire cleared" : "R9 strobes cleared", 64'(v),
                isnew ? 64'(c & ~32'h0000_8000) : 64'(c & ~32'h0C00_0000));
        end

        // R6: start flag clear
        wr(2'd2, 32'h8000_0000);
        c = new_word(16'h1234, 1'b1, 1'b0, 2'b01, 5'd3, 5'd4);
        falls = 0; rises = 0;
        wr(2'd0, c);
        repeat (20) @(negedge clk);
        chk("R6 no frame", {32'(rises), 31'h0, busy}, 64'h0);
        rd(2'd0, v); chk("R6 ctrl kept", 64'(v), 64'(c));

        // R7: invalid ops
        for (int k = 0; k < 2; k++) begin
            c = new_word(16'hBEEF, 1'b1, 1'b1, (k == 0) ? 2'b00 : 2'b11, 5'd7, 5'd9);
            rises = 0;
            wr(2'd0, c);
            repeat (20) @(negedge clk);
            chk("R7 no frame", {32'(rises), 31'h0, busy}, 64'h0);
            rd(2'd0, v); chk("R7 fire dropped", 64'(v), 64'(c & ~32'h0000_8000));
        end

        // R10: legacy, neither strobe
        wr(2'd2, 32'h0);
        rises = 0;
        wr(2'd0, leg_word(1'b0, 1'b0, 5'd1, 5'd2));
        repeat (20) @(negedge clk);
        chk("R10 no frame", {32'(rises), 31'h0, busy}, 64'h0);

        // R8: both strobes -> write wins
        wr(2'd1, 32'h0000_A5C3);
        issue(leg_word(1'b1, 1'b1, 5'd17, 5'd22));
        chk("R8 both strobes write", cap_d, exp_frame(1'b0, 5'd17, 5'd22, 16'hA5C3));
        rd(2'd1, v); chk("R8 data unchanged", 64'(v), 64'h0000_A5C3);

        // R11: busy interlock, period
        wr(2'd2, 32'h8000_0000);
        falls = 0; rises = 0; cap_d = '0;
        c = new_word(16'h0F0F, 1'b1, 1'b1, 2'b01, 5'd5, 5'd6);
        wr(2'd0, c);
        repeat (10) @(negedge clk);
        chk("R11 busy high", 64'(busy), 64'h1);
        wr(2'd0, new_word(16'hFFFF, 1'b1, 1'b1, 2'b10, 5'd31, 5'd31));
        r0 = 0;
        wait_idle();
        chk("R11 first frame intact", cap_d, exp_frame(1'b0, 5'd5, 5'd6, 16'h0F0F));
        chk("R11 mdc period", 64'(period), 64'(2 * DIV));
        rd(2'd0, v); chk("R11 ctrl from first write", 64'(v), 64'(c & ~32'h0000_8000));
        rises = 0;
        repeat (20) @(negedge clk);
        chk("R11 no second frame", 64'(rises + r0), 64'h0);

        // R12: idle pins
        chk("R12 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule